// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from five sources, keeps a latched pending flag for each one, and decides which request the processor services next. Software can enable each source on its own, and a master enable gates all of them. Software can also overwrite the pending flags directly.

The decision is made only in a cycle where the sampling strobe is high. In such a cycle the highest-priority request that is pending and enabled is taken, provided the master enable is set and the call stack has room. Taking it produces a one-cycle take pulse with the fixed vector address of the winning source. Taking it also clears that source's flag and the master enable, so nothing else is taken until the service routine returns through the enable-restoring return.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all pending flags, all source enables and the master enable are clear, `take` is 0 and `vector` is 0. A strobe given before any enable is written takes nothing.
- R2: Priority runs from `src_req` bit 0 (highest) to bit 4 (lowest). The vectors for bits 0 to 4 are 0x04, 0x08, 0x0C, 0x14 and 0x18.
- R3: A source is taken only when all of these hold in the strobe cycle: the master enable is set, its enable bit is set, its flag is set and `stack_full` is 0.
- R4: Taking a source clears its flag and the master enable. The other flags stay pending and are not taken until the master enable is set again.
- R5: A flag set by a `src_req` pulse stays set until it is taken or overwritten. Writing `flag_wr` loads `flag_wdata` into all flags. A `src_req` pulse in the same cycle still sets its flag.
- R6: A `ret_reti` pulse sets the master enable. `gie_wr` loads `gie_wdata` into it.
- R7: Flags are examined only in a cycle where `strobe` is 1. A request pulsed in the strobe cycle itself waits for the next strobe.
- R8: `take` rises in the cycle after the deciding strobe and lasts one cycle. `vector` carries the winner's address in that cycle and is 0 in all other cycles.
- R9: When a take coincides with `ret_reti` or `gie_wr`, the take wins and the master enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 5 | Request pulses, one bit per source |
| flag_wr | input | 1 | Software write of all pending flags |
| flag_wdata | input | 5 | New flag values |
| en_wr | input | 1 | Software write of the source enables |
| en_wdata | input | 5 | New enable values |
| gie_wr | input | 1 | Software write of the master enable |
| gie_wdata | input | 1 | New master enable value |
| stack_full | input | 1 | Call stack has no free entry |
| strobe | input | 1 | Sampling phase strobe |
| ret_reti | input | 1 | Return-from-interrupt that restores the master enable |
| take | output | 1 | One-cycle interrupt take pulse |
| vector | output | 8 | Vector address of the taken source |

## Verification
The bench fills all five flags and releases the master enable one return at a time. The vectors must come out in strict priority order. A design with a flipped encoder or a swapped vector would break that sequence. The stack-full, disabled-source and cleared-master cases each block the take, so a missing term in the gating lets a take escape. A request pulsed in the strobe cycle must wait for the next strobe, and a return that coincides with a take must leave the master enable clear. A design that samples too early, or that lets the return win, would show an extra take.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 8;

    typedef logic [NSRC-1:0]  src_vec_t;
    typedef logic [VEC_W-1:0] vec_addr_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic      take;
        vec_addr_t addr;
    } grant_t;

    function automatic vec_addr_t vec_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 8'h04;
            3'd1:    return 8'h08;
            3'd2:    return 8'h0C;
            3'd3:    return 8'h14;
            default: return 8'h18;
        endcase
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_pulse,
    input  logic     wr,
    input  src_vec_t wdata,
    input  logic     clr_en,
    input  src_vec_t clr_mask,
    output src_vec_t flags
);
    src_vec_t base;

    always_comb begin
        if (wr)          base = wdata;
        else if (clr_en) base = flags & ~clr_mask;
        else             base = flags;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= base | set_pulse;
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  src_vec_t pending,
    output pick_t    pick,
    output src_vec_t onehot
);
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick.hit = 1'b1;
                pick.idx = IDX_W'(i);
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_oh
            assign onehot[g] = pick.hit && (pick.idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl
    import irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pick_t  pick,
    input  logic   strobe,
    input  logic   stack_full,
    input  logic   reti,
    input  logic   gie_wr,
    input  logic   gie_wdata,
    output logic   fire,
    output logic   gie,
    output grant_t grant
);
    assign fire = strobe && gie && !stack_full && pick.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie   <= 1'b0;
            grant <= '0;
        end else begin
            if (fire)        gie <= 1'b0;
            else if (reti)   gie <= 1'b1;
            else if (gie_wr) gie <= gie_wdata;
            grant.take <= fire;
            grant.addr <= fire ? vec_of(pick.idx) : '0;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] src_req,
    input  logic       flag_wr,
    input  logic [4:0] flag_wdata,
    input  logic       en_wr,
    input  logic [4:0] en_wdata,
    input  logic       gie_wr,
    input  logic       gie_wdata,
    input  logic       stack_full,
    input  logic       strobe,
    input  logic       ret_reti,
    output logic       take,
    output logic [7:0] vector
);
    src_vec_t flags_q, en_q, clr_oh;
    pick_t    pick;
    grant_t   grant;
    logic     fire, gie_q;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    irq_flag_bank u_flags (
        .clk(clk), .rst(rst), .set_pulse(src_req), .wr(flag_wr),
        .wdata(flag_wdata), .clr_en(fire), .clr_mask(clr_oh), .flags(flags_q)
    );

    irq_prio_pick u_pick (
        .pending(flags_q & en_q), .pick(pick), .onehot(clr_oh)
    );

    irq_take_ctl u_ctl (
        .clk(clk), .rst(rst), .pick(pick), .strobe(strobe),
        .stack_full(stack_full), .reti(ret_reti), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .fire(fire), .gie(gie_q), .grant(grant)
    );

    assign take   = grant.take;
    assign vector = grant.addr;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe,
    input logic       stack_full,
    input logic       take,
    input logic [7:0] vector,
    input logic       gie
);
    // R8
    take_single_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);
    // R8
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !take |-> vector == 8'h00);
    // R2
    vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (vector == 8'h04 || vector == 8'h08 || vector == 8'h0C ||
                  vector == 8'h14 || vector == 8'h18));
    // R7
    take_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(take) |-> $past(strobe));
    // R3
    take_stack_room_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(take) |-> !$past(stack_full));
    // R4
    gie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> !gie);
endmodule

bind vec_irq_ctrl irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .strobe(strobe), .stack_full(stack_full),
    .take(take), .vector(vector), .gie(gie_q)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
    logic       clk = 0;
    logic       rst;
    logic [4:0] src_req, flag_wdata, en_wdata;
    logic       flag_wr, en_wr, gie_wr, gie_wdata, stack_full, strobe, ret_reti;
    logic       take;
    logic [7:0] vector;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // reference state
    bit [4:0] m_flags, m_en;
    bit       m_gie, m_take;
    int       m_vec;

    always #4 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst(rst), .src_req(src_req), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .stack_full(stack_full),
        .strobe(strobe), .ret_reti(ret_reti), .take(take), .vector(vector)
    );

    function automatic int addr_for(int k);
        int tbl[5] = '{4, 8, 12, 20, 24};
        return tbl[k];
    endfunction

    task automatic idle();
        src_req = 0; flag_wr = 0; flag_wdata = 0; en_wr = 0; en_wdata = 0;
        gie_wr = 0; gie_wdata = 0; stack_full = 0; strobe = 0; ret_reti = 0;
    endtask

    task automatic model();
        bit [4:0] pend, nf;
        int win;
        bit fire;
        if (rst) begin
            m_flags = 0; m_en = 0; m_gie = 0; m_take = 0; m_vec = 0;
            return;
        end
        pend = m_flags & m_en;
        win = -1;
        for (int i = 4; i >= 0; i--) if (pend[i]) win = i;
        fire = strobe && m_gie && !stack_full && (win >= 0);
        nf = m_flags;
        if (flag_wr) nf = flag_wdata;
        else if (fire) nf[win] = 1'b0;
        m_flags = nf | src_req;
        if (en_wr) m_en = en_wdata;
        if (fire) m_gie = 0;
        else if (ret_reti) m_gie = 1;
        else if (gie_wr) m_gie = gie_wdata;
        m_take = fire;
        m_vec = fire ? addr_for(win) : 0;
    endtask

    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        n_chk++;
        if (take !== m_take) begin
            n_fail++;
            $display("FAIL %s take actual=%0b expected=%0b", cur_req, take, m_take);
        end
        n_chk++;
        if (vector !== 8'(m_vec)) begin
            n_fail++;
            $display("FAIL %s vector actual=%0h expected=%0h", cur_req, vector, m_vec);
        end
        idle();
    endtask

    task automatic set_gie();
        gie_wr = 1; gie_wdata = 1; step();
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        step(); step();
        rst = 0;
        // R1: reset state, and an unenabled strobe takes nothing
        cur_req = "R1";
        step();
        flag_wr = 1; flag_wdata = 5'h1F; step();
        strobe = 1; step(); step();

        // R3: each gating term blocks on its own
        cur_req = "R3";
        flag_wr = 1; flag_wdata = 5'h01; en_wr = 1; en_wdata = 5'h1E; step();
        set_gie();
        strobe = 1; step(); step();
        en_wr = 1; en_wdata = 5'h1F; step();
        strobe = 1; stack_full = 1; step(); step();
        gie_wr = 1; gie_wdata = 0; step();
        strobe = 1; step(); step();
        set_gie();
        strobe = 1; step(); step();

        // R2 / R4: drain all five in priority order
        cur_req = "R2";
        flag_wr = 1; flag_wdata = 5'h1F; step();
        set_gie();
        for (int k = 0; k < 5; k++) begin
            strobe = 1; step(); step();
            cur_req = "R4";
            strobe = 1; step(); step();
            cur_req = "R6";
            ret_reti = 1; step();
            cur_req = "R2";
        end

        // R7: request arriving in the strobe cycle waits
        cur_req = "R7";
        strobe = 1; src_req = 5'h04; step(); step();
        step(); step();
        strobe = 1; step(); step();
        ret_reti = 1; step();

        // R5: flags persist, software write replaces, pulse ORs in
        cur_req = "R5";
        src_req = 5'h10; step();
        step(); step(); step();
        flag_wr = 1; flag_wdata = 5'h00; step();
        strobe = 1; step(); step();
        flag_wr = 1; flag_wdata = 5'h08; src_req = 5'h02; step();
        strobe = 1; step(); step();
        ret_reti = 1; step();
        strobe = 1; step(); step();

        // R9: take wins over a coinciding return
        cur_req = "R9";
        flag_wr = 1; flag_wdata = 5'h06; step();
        ret_reti = 1; step();
        strobe = 1; ret_reti = 1; step(); step();
        strobe = 1; step(); step();
        strobe = 1; gie_wr = 1; gie_wdata = 1; step(); step();

        // R8: pulse width and idle vector
        cur_req = "R8";
        for (int k = 0; k < 4; k++) step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule